// File: doc/BRIEF.md
# Access Permission Checker with Fault Status

This block judges one memory access per cycle against the 3-bit permission field of a leaf translation descriptor. A table walker presents the descriptor's permission field together with its own verdict on the walk. The block combines these with the access kind and the privilege level of the requester. It then decides in the same cycle whether the access may proceed. If not, it names the class of error.

Every refused access is logged in two read-only registers: a fault status word and a fault address. A single read strobe returns both registers and clears them. A fault that arrives while the status word still holds an unread value sets an overflow flag, so software can tell that one report was lost.

A no-fault mode lets user-level permission violations through without logging them. This serves speculative or probing accesses. Walker-reported faults are never masked by this mode.

Top module: `access_guard`

## Requirements
- R1: The access index is the 3-bit value {write, fetch, supervisor} (write in bit 2, supervisor in bit 0). On every logged fault it appears in status bits [7:5].
- R2: Rights per permission value p are given as (supervisor rights; user rights), with R = read, W = write, X = execute:
  - p=0: (R; R)
  - p=1: (RW; RW)
  - p=2: (RX; RX)
  - p=3: (RWX; RWX)
  - p=4: (X; X)
  - p=5: (RW; R)
  - p=6: (RX; none)
  - p=7: (RWX; none)
  A load needs R, a store needs W, a fetch needs X, and an access flagged as both store and fetch needs W and X.
- R3: A user access with permission value 6 or 7 is refused with error code 3 (privilege), whatever its kind.
- R4: Any other access lacking a needed right is refused with error code 2 (protection). A permitted access raises acc_allow with error code 0.
- R5: With nofault_en high, a user access that fails R3 or R4 is allowed with error code 0 and leaves the status and address registers unchanged. Supervisor accesses are unaffected by nofault_en.
- R6: A non-zero walk_ftype refuses the access with error code 1, whatever nofault_en is. The status word then holds walk_ftype in bits [4:2] and walk_level in bits [9:8].
- R7: A logged fault sets status bit 1 and captures acc_vaddr in far_q one cycle after the access. For a permission fault, status bits [4:2] hold the error code (2 or 3) and bits [9:8] are 0.
- R8: A fault that arrives while the status word is non-zero and no read is taking place yields status = 1 OR the new fault word. The earlier fields are dropped and bit 0 flags the overflow.
- R9: A cycle with fsr_rd high presents the current register values and clears both registers at the next edge, unless R10 applies.
- R10: A fault in the same cycle as a read is logged as a fresh report without the overflow flag.
- R11: After reset both registers read 0.
- R12: With acc_valid low, acc_allow and acc_err are 0 and nothing is logged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | Access is a store |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Requester runs at supervisor level |
| acc_perm | input | 3 | Permission field of the leaf descriptor |
| acc_vaddr | input | VA_W | Virtual address of the access |
| nofault_en | input | 1 | No-fault mode for user accesses |
| walk_ftype | input | 3 | Walker fault type, 0 when the walk succeeded |
| walk_level | input | 2 | Table level at which the walker stopped |
| fsr_rd | input | 1 | Read strobe for the fault registers |
| acc_allow | output | 1 | Access may proceed |
| acc_err | output | 2 | 0 none, 1 walker, 2 protection, 3 privilege |
| fsr_q | output | 10 | Fault status word |
| far_q | output | VA_W | Fault address |

## Verification
A wrong permission decode shows at once on acc_allow and acc_err, in the same cycle the access is presented. The vector walk spans every access kind under both privilege levels. A wrong access index, field placement or overflow decision stays hidden until the edge after the fault. It then appears in fsr_q, so each vector reads the status word back one cycle later and compares it with a word built from the field positions. Clear-on-read and the read-versus-fault collision are only visible over two consecutive cycles. Directed sequences therefore chain faults and reads back to back and check the registers at each step.

// File: rtl/access_guard_pkg.sv
package access_guard_pkg;

  localparam int FSR_W    = 10;
  localparam int OVF_BIT  = 0;
  localparam int VLD_BIT  = 1;
  localparam int TYPE_LSB = 2;
  localparam int TYPE_W   = 3;
  localparam int IDX_LSB  = 5;
  localparam int IDX_W    = 3;
  localparam int LVL_LSB  = 8;
  localparam int LVL_W    = 2;

  localparam logic [TYPE_W-1:0] TYPE_PROT = 3'd2;
  localparam logic [TYPE_W-1:0] TYPE_PRIV = 3'd3;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_WALK = 2'd1,
    ERR_PROT = 2'd2,
    ERR_PRIV = 2'd3
  } err_kind_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

endpackage

// File: rtl/ag_rst_sync.sv
module ag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ag_perm_rights.sv
module ag_perm_rights
  import access_guard_pkg::*;
(
  input  logic [2:0] perm,
  input  logic       is_super,
  output rights_t    rights,
  output logic       priv_block
);

  // User level loses every right on the two supervisor-only encodings.
  always_comb begin
    rights = '0;
    if (is_super) begin
      unique case (perm)
        3'd0: rights = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
        3'd1: rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
        3'd2: rights = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
        3'd3: rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
        3'd4: rights = '{rd: 1'b0, wr: 1'b0, ex: 1'b1};
        3'd5: rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
        3'd6: rights = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
        default: rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
      endcase
    end else begin
      unique case (perm)
        3'd0: rights = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
        3'd1: rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
        3'd2: rights = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
        3'd3: rights = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
        3'd4: rights = '{rd: 1'b0, wr: 1'b0, ex: 1'b1};
        3'd5: rights = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
        default: rights = '0;
      endcase
    end
  end

  assign priv_block = !is_super && (perm[2:1] == 2'b11);

endmodule

// File: rtl/ag_access_judge.sv
module ag_access_judge
  import access_guard_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic            is_write,
  input  logic            is_fetch,
  input  logic            is_super,
  input  logic [2:0]      perm,
  input  logic            nofault,
  input  logic [2:0]      walk_ftype,
  output logic [IDX_W-1:0] acc_idx,
  output logic            allow,
  output err_kind_e       err
);

  rights_t   rights;
  logic      priv_block;
  logic      need_rd;
  logic      missing;
  logic      user_masked;
  err_kind_e perm_err;

  ag_perm_rights u_rights (
    .perm       (perm),
    .is_super   (is_super),
    .rights     (rights),
    .priv_block (priv_block)
  );

  assign acc_idx = {is_write, is_fetch, is_super};
  assign need_rd = !is_write && !is_fetch;

  always_comb begin
    missing = (need_rd && !rights.rd) ||
              (is_write && !rights.wr) ||
              (is_fetch && !rights.ex);
    if (priv_block) begin
      perm_err = ERR_PRIV;
    end else if (missing) begin
      perm_err = ERR_PROT;
    end else begin
      perm_err = ERR_NONE;
    end
  end

  assign user_masked = nofault && !is_super;

  always_comb begin
    allow = 1'b0;
    err   = ERR_NONE;
    if (valid) begin
      if (walk_ftype != 3'd0) begin
        err = ERR_WALK;
      end else if ((perm_err != ERR_NONE) && !user_masked) begin
        err = perm_err;
      end else begin
        allow = 1'b1;
      end
    end
  end

  // R3: user access to supervisor-only encodings is a privilege error
  assert_priv_user_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !is_super && perm[2:1] == 2'b11 && walk_ftype == 3'd0 && !nofault)
      |-> (err == ERR_PRIV && !allow));

  // R5: no-fault mode lets every successfully walked user access through
  assert_nofault_pass_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (valid && nofault && !is_super && walk_ftype == 3'd0) |-> (allow && err == ERR_NONE));

  // R6: walker faults are never masked
  assert_walk_refuse_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (valid && walk_ftype != 3'd0) |-> (!allow && err == ERR_WALK));

endmodule

// File: rtl/ag_fault_regs.sv
module ag_fault_regs
  import access_guard_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_ev,
  input  logic [FSR_W-1:0] fault_word,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             rd,
  output logic [FSR_W-1:0] fsr_q,
  output logic [VA_W-1:0]  far_q
);

  localparam logic [FSR_W-1:0] OVF_WORD = FSR_W'(1) << OVF_BIT;

  logic [FSR_W-1:0] base;
  logic [FSR_W-1:0] fsr_d;
  logic [VA_W-1:0]  far_d;
  logic             fsr_en;
  logic             far_en;

  // A read in the same cycle consumes the old report before the new one lands.
  always_comb begin
    base = rd ? '0 : fsr_q;
    fsr_d = base;
    if (fault_ev) begin
      fsr_d = ((base != '0) ? OVF_WORD : '0) | fault_word;
    end
    far_d = fault_ev ? vaddr : '0;
    fsr_en = fault_ev || rd;
    far_en = fault_ev || rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else begin
      if (fsr_en) fsr_q <= fsr_d;
      if (far_en) far_q <= far_d;
    end
  end

  // R9: a read with no fault empties the status word
  assert_read_clears_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !fault_ev) |=> (fsr_q == '0 && far_q == '0));

  // R8: a fault on top of an unread report flags overflow
  assert_overflow_flag_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ev && !rd && fsr_q != '0) |=> fsr_q[OVF_BIT]);

  // R10: a fault during a read is a fresh report
  assert_collide_fresh_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ev && rd) |=> !fsr_q[OVF_BIT]);

  // R7: every fault marks the report valid and captures its address
  assert_capture_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    fault_ev |=> (fsr_q[VLD_BIT] && far_q == $past(vaddr)));

  // R12: without fault or read the registers hold
  assert_hold_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_ev && !rd) |=> ($stable(fsr_q) && $stable(far_q)));

endmodule

// File: rtl/access_guard.sv
module access_guard
  import access_guard_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_fetch,
  input  logic             acc_super,
  input  logic [2:0]       acc_perm,
  input  logic [VA_W-1:0]  acc_vaddr,
  input  logic             nofault_en,
  input  logic [2:0]       walk_ftype,
  input  logic [1:0]       walk_level,
  input  logic             fsr_rd,
  output logic             acc_allow,
  output logic [1:0]       acc_err,
  output logic [FSR_W-1:0] fsr_q,
  output logic [VA_W-1:0]  far_q
);

  logic             rst_n_s;
  logic [IDX_W-1:0] acc_idx;
  err_kind_e        err_kind;
  logic             fault_ev;
  logic [FSR_W-1:0] fault_word;
  logic [TYPE_W-1:0] f_type;
  logic [LVL_W-1:0]  f_level;

  ag_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ag_access_judge u_judge (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .valid      (acc_valid),
    .is_write   (acc_write),
    .is_fetch   (acc_fetch),
    .is_super   (acc_super),
    .perm       (acc_perm),
    .nofault    (nofault_en),
    .walk_ftype (walk_ftype),
    .acc_idx    (acc_idx),
    .allow      (acc_allow),
    .err        (err_kind)
  );

  always_comb begin
    f_type  = TYPE_PROT;
    f_level = '0;
    unique case (err_kind)
      ERR_WALK: begin
        f_type  = walk_ftype;
        f_level = walk_level;
      end
      ERR_PRIV: f_type = TYPE_PRIV;
      default:  f_type = TYPE_PROT;
    endcase
    fault_word = '0;
    fault_word[VLD_BIT]               = 1'b1;
    fault_word[TYPE_LSB +: TYPE_W]    = f_type;
    fault_word[IDX_LSB  +: IDX_W]     = acc_idx;
    fault_word[LVL_LSB  +: LVL_W]     = f_level;
  end

  assign fault_ev = (err_kind != ERR_NONE);
  assign acc_err  = err_kind;

  ag_fault_regs #(.VA_W(VA_W)) u_fregs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .fault_ev   (fault_ev),
    .fault_word (fault_word),
    .vaddr      (acc_vaddr),
    .rd         (fsr_rd),
    .fsr_q      (fsr_q),
    .far_q      (far_q)
  );

  // R12: an idle cycle neither allows nor reports
  assert_idle_quiet_R12 : assert property (@(posedge clk) disable iff (!rst_n_s)
    !acc_valid |-> (!acc_allow && acc_err == 2'd0));

endmodule

// File: tb/access_guard_tb.sv
`timescale 1ns/1ps
module access_guard_tb;
  localparam int VA_W = 32;
  localparam int NVEC = 20;

  // vector: {write,fetch,super}_{perm}_{nofault}_{allow}_{err}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b000_000_0_1_00, 10'b000_100_0_0_10, 10'b000_110_0_0_11, 10'b001_100_0_0_10,
    10'b001_111_0_1_00, 10'b010_101_0_0_10, 10'b010_100_0_1_00, 10'b011_110_0_1_00,
    10'b011_001_0_0_10, 10'b100_001_0_1_00, 10'b100_010_0_0_10, 10'b101_101_0_1_00,
    10'b101_110_0_0_10, 10'b110_011_0_1_00, 10'b111_111_0_1_00, 10'b111_110_0_0_10,
    10'b000_100_1_1_00, 10'b000_111_1_1_00, 10'b001_100_1_0_10, 10'b100_111_0_0_11
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, acc_valid, acc_write, acc_fetch, acc_super, nofault_en, fsr_rd;
  logic [2:0] acc_perm, walk_ftype;
  logic [1:0] walk_level;
  logic [VA_W-1:0] acc_vaddr;
  logic acc_allow;
  logic [1:0] acc_err;
  logic [9:0] fsr_q;
  logic [VA_W-1:0] far_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  access_guard #(.VA_W(VA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_fetch(acc_fetch), .acc_super(acc_super), .acc_perm(acc_perm),
    .acc_vaddr(acc_vaddr), .nofault_en(nofault_en), .walk_ftype(walk_ftype),
    .walk_level(walk_level), .fsr_rd(fsr_rd), .acc_allow(acc_allow),
    .acc_err(acc_err), .fsr_q(fsr_q), .far_q(far_q)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid = 0; acc_write = 0; acc_fetch = 0; acc_super = 0; acc_perm = 0;
    nofault_en = 0; walk_ftype = 0; walk_level = 0; fsr_rd = 0; acc_vaddr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(fsr_q == 0, "R11 fsr", fsr_q, 0);
    chk(far_q == 0, "R11 far", far_q, 0);
    chk(!acc_allow && acc_err == 0, "R12 idle", {acc_allow, acc_err}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] idx;
      logic [1:0] eerr;
      logic       eallow;
      logic [9:0] efsr;
      logic [VA_W-1:0] va;
      idx = VEC[i][9:7]; eallow = VEC[i][2]; eerr = VEC[i][1:0];
      va = 32'h1000_0000 + 32'(i) * 32'h40;
      acc_valid = 1; acc_write = idx[2]; acc_fetch = idx[1]; acc_super = idx[0];
      acc_perm = VEC[i][6:4]; nofault_en = VEC[i][3]; acc_vaddr = va;
      #1;
      if (eerr == 2'd3)      chk(acc_allow == eallow && acc_err == eerr, "R3 verdict", {acc_allow, acc_err}, {eallow, eerr});
      else if (VEC[i][3])    chk(acc_allow == eallow && acc_err == eerr, "R5 verdict", {acc_allow, acc_err}, {eallow, eerr});
      else if (eerr == 2'd2) chk(acc_allow == eallow && acc_err == eerr, "R4 verdict", {acc_allow, acc_err}, {eallow, eerr});
      else                   chk(acc_allow == eallow && acc_err == eerr, "R2 verdict", {acc_allow, acc_err}, {eallow, eerr});
      @(negedge clk);
      idle();
      // R1 and R7: index in [7:5], code in [4:2], bit 1 set
      efsr = (eerr != 0) ? ((10'(idx) << 5) | (10'(eerr) << 2) | 10'd2) : 10'd0;
      chk(fsr_q == efsr, "R1 fsr word", fsr_q, efsr);
      chk(far_q == ((eerr != 0) ? va : '0), "R7 far", far_q, (eerr != 0) ? va : 0);
      fsr_rd = 1;
      @(negedge clk);
      fsr_rd = 0;
      chk(fsr_q == 0 && far_q == 0, "R9 cleared", fsr_q, 0);
    end

    // R6: walker fault despite no-fault mode, user store idx 4, level 2
    acc_valid = 1; acc_write = 1; acc_perm = 3'd3; nofault_en = 1;
    walk_ftype = 3'd1; walk_level = 2'd2; acc_vaddr = 32'hDEAD_B000;
    #1;
    chk(!acc_allow && acc_err == 2'd1, "R6 verdict", {acc_allow, acc_err}, 1);
    @(negedge clk);
    chk(fsr_q == 10'd646, "R6 fsr", fsr_q, 646);
    chk(far_q == 32'hDEAD_B000, "R6 far", far_q, 32'hDEAD_B000);

    // R8: protection fault on an unread report, user store perm 2
    idle();
    acc_valid = 1; acc_write = 1; acc_perm = 3'd2; acc_vaddr = 32'h0000_5004;
    @(negedge clk);
    chk(fsr_q == 10'd139, "R8 overflow", fsr_q, 139);
    chk(far_q == 32'h0000_5004, "R8 far", far_q, 32'h5004);

    // R10: privilege fault in the same cycle as a read
    idle();
    acc_valid = 1; acc_perm = 3'd6; acc_vaddr = 32'h0000_7008; fsr_rd = 1;
    #1;
    chk(fsr_q == 10'd139, "R9 read data", fsr_q, 139);
    @(negedge clk);
    chk(fsr_q == 10'd14, "R10 fresh", fsr_q, 14);
    chk(far_q == 32'h0000_7008, "R10 far", far_q, 32'h7008);

    // R12: invalid access with a bad permission is ignored
    idle();
    acc_perm = 3'd4;
    #1;
    chk(!acc_allow && acc_err == 0, "R12 verdict", {acc_allow, acc_err}, 0);
    @(negedge clk);
    chk(fsr_q == 10'd14 && far_q == 32'h0000_7008, "R12 hold", fsr_q, 14);

    // R9: plain read empties both registers
    idle();
    fsr_rd = 1;
    @(negedge clk);
    fsr_rd = 0;
    chk(fsr_q == 0 && far_q == 0, "R9 clear", fsr_q, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule